// File: doc/BRIEF.md
# Set-Associative Data Translation Cache

This block keeps recently completed address translations close to the load/store pipe, so that an access whose page has already been walked does not pay for a second walk. Each cycle it can accept one lookup of a virtual page number. One clock later it answers with a hit flag, the physical page number and seven attribute bits. On a miss it raises a walk request that carries the missing page number. When the walker finishes, it installs the entry through a separate install port.

The cache holds 4 KB pages in a two-way array whose set count is a parameter (32 by default). Each set has one least-recently-used bit. An invalidate port takes a byte-address operand. A page-aligned operand drops only the entry for that page. The special value 0xC00 empties the whole array at once.

Top module: `dtlb_cache`

## Requirements
- R1: After reset every entry is invalid and rspValid and missReq are low, so the first lookup of any page misses.
- R2: A lookup presented with lkValid at a clock edge produces rspValid for exactly one cycle after that edge, and back-to-back lookups give back-to-back responses. The answer reflects the array contents before that edge, so an install made at the same edge is not seen.
- R3: On a miss rspHit is low, missReq is high in the same cycle as rspValid, missVpn equals the looked-up page number, and rspPpn and rspAttr are zero.
- R4: A page installed at one edge hits from the next edge on. The response returns the installed physical page number and the seven attribute bits unchanged: bit 0 execute, bit 1 write, bit 2 read, bit 3 privileged, bit 4 non-cacheable, bit 5 referenced, bit 6 changed.
- R5: The set is chosen by the low log2(NUM_SETS) page-number bits, and the remaining bits form the tag. Two pages that share a set (for example pages 0x124 and 0x1124) both remain resident once both are installed.
- R6: An install into a set fills an invalid way first (way 0 before way 1). If both ways are valid, it replaces the way named by the set's LRU bit. Each hit and each install makes the other way of that set the next victim.
- R7: Installing a page that is already resident overwrites its own way with the new contents. It does not create a second copy and does not evict the other way.
- R8: An invalidate whose operand has bits 11:0 equal to zero removes only the entry whose page equals operand bits 31:12. Other entries, including one in the same set, stay resident.
- R9: An invalidate with operand exactly 0xC00 clears every entry at the next edge.
- R10: An invalidate operand whose bits 11:0 are nonzero and that is not 0xC00 has no effect on the contents.
- R11: When install and invalidate are presented at the same edge, the install is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkVpn | input | ADDR_W-12 | Virtual page number to look up |
| instValid | input | 1 | Install a completed translation |
| instVpn | input | ADDR_W-12 | Page number of the installed entry |
| instPpn | input | PPN_W | Physical page number of the installed entry |
| instAttr | input | 7 | Attribute bits of the installed entry |
| invValid | input | 1 | Invalidate command this cycle |
| invOperand | input | ADDR_W | Page address to drop, or 0xC00 to flush all |
| rspValid | output | 1 | Lookup response valid |
| rspHit | output | 1 | Lookup found a resident entry |
| rspPpn | output | PPN_W | Physical page number on a hit, zero on a miss |
| rspAttr | output | 7 | Attribute bits on a hit, zero on a miss |
| missReq | output | 1 | Walk request for the missed page |
| missVpn | output | ADDR_W-12 | Page number to be walked |

## Verification
A corrupted valid, tag or LRU bit surfaces on the first lookup of the affected set after the corruption. That lookup shows a wrong hit flag, a wrong physical page, or a walk request one cycle after it was issued. Replacement order is checked by filling a set beyond two pages in controlled orders and then probing all three pages. A wrong victim choice therefore shows up as a hit where a miss is expected, or the reverse. Invalidate decoding is probed with a page address, the flush code and two near-miss operands, each followed by lookups of neighbouring entries in the same set.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int ATTR_W = 7;
  localparam int WAYS = 2;
  localparam logic [11:0] FLUSH_OP = 12'hC00;

  typedef struct packed {
    logic       rspEn;
    logic       lkHit;
    logic       lkWay;
    logic       fill;
    logic       fillWay;
    logic       flushAll;
    logic [1:0] dropWays;
  } tlbStrobe_t;
endpackage

// File: rtl/dtlb_ctrl.sv
module dtlb_ctrl
  import dtlb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              lkValid,
  input  logic              instValid,
  input  logic              invValid,
  input  logic [ADDR_W-1:0] invOperand,
  input  logic [WAYS-1:0]   lkMatch,
  input  logic [WAYS-1:0]   fillValid,
  input  logic [WAYS-1:0]   fillMatch,
  input  logic              fillLru,
  input  logic [WAYS-1:0]   dropMatch,
  output tlbStrobe_t        st
);
  logic isFlush;
  logic isPage;

  assign isFlush = invValid && (invOperand == ADDR_W'(FLUSH_OP));
  assign isPage  = invValid && (invOperand[PAGE_SHIFT-1:0] == '0);

  always_comb begin
    st          = '0;
    st.rspEn    = lkValid;
    st.lkHit    = lkValid && (|lkMatch);
    st.lkWay    = lkMatch[1];
    st.flushAll = isFlush;
    st.dropWays = isPage ? dropMatch : 2'b00;
    st.fill     = instValid && !invValid;
    if (|fillMatch)        st.fillWay = fillMatch[1];
    else if (!fillValid[0]) st.fillWay = 1'b0;
    else if (!fillValid[1]) st.fillWay = 1'b1;
    else                    st.fillWay = fillLru;
  end
endmodule

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PPN_W    = 20,
  parameter int NUM_SETS = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tlbStrobe_t                   st,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lkVpn,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] instVpn,
  input  logic [PPN_W-1:0]             instPpn,
  input  logic [ATTR_W-1:0]            instAttr,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] invVpn,
  output logic [WAYS-1:0]              lkMatch,
  output logic [WAYS-1:0]              fillValid,
  output logic [WAYS-1:0]              fillMatch,
  output logic                         fillLru,
  output logic [WAYS-1:0]              dropMatch,
  output logic                         rspValid,
  output logic                         rspHit,
  output logic [PPN_W-1:0]             rspPpn,
  output logic [ATTR_W-1:0]            rspAttr,
  output logic                         missReq,
  output logic [ADDR_W-PAGE_SHIFT-1:0] missVpn
);
  localparam int VPN_W = ADDR_W - PAGE_SHIFT;
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int TAG_W = VPN_W - SET_W;

  logic [SET_W-1:0] lkSet, instSet, invSet;
  logic [TAG_W-1:0] lkTag, instTag, invTag;
  logic [WAYS-1:0][PPN_W-1:0]  wayPpn;
  logic [WAYS-1:0][ATTR_W-1:0] wayAttr;
  logic [NUM_SETS-1:0] lruQ;

  assign lkSet   = lkVpn[SET_W-1:0];
  assign lkTag   = lkVpn[VPN_W-1:SET_W];
  assign instSet = instVpn[SET_W-1:0];
  assign instTag = instVpn[VPN_W-1:SET_W];
  assign invSet  = invVpn[SET_W-1:0];
  assign invTag  = invVpn[VPN_W-1:SET_W];
  assign fillLru = lruQ[instSet];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [NUM_SETS-1:0] validQ;
    logic [TAG_W-1:0]    tagQ  [NUM_SETS];
    logic [PPN_W-1:0]    ppnQ  [NUM_SETS];
    logic [ATTR_W-1:0]   attrQ [NUM_SETS];
    logic                fillHere;

    assign fillHere     = st.fill && (st.fillWay == 1'(w));
    assign lkMatch[w]   = validQ[lkSet] && (tagQ[lkSet] == lkTag);
    assign fillValid[w] = validQ[instSet];
    assign fillMatch[w] = validQ[instSet] && (tagQ[instSet] == instTag);
    assign dropMatch[w] = validQ[invSet] && (tagQ[invSet] == invTag);
    assign wayPpn[w]    = ppnQ[lkSet];
    assign wayAttr[w]   = attrQ[lkSet];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= '0;
      end else if (st.flushAll) begin
        validQ <= '0;
      end else begin
        if (st.dropWays[w]) validQ[invSet] <= 1'b0;
        if (fillHere)       validQ[instSet] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fillHere) begin
        tagQ[instSet]  <= instTag;
        ppnQ[instSet]  <= instPpn;
        attrQ[instSet] <= instAttr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruQ <= '0;
    end else begin
      if (st.lkHit) lruQ[lkSet]   <= ~st.lkWay;
      if (st.fill)  lruQ[instSet] <= ~st.fillWay;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspPpn   <= '0;
      rspAttr  <= '0;
      missReq  <= 1'b0;
      missVpn  <= '0;
    end else begin
      rspValid <= st.rspEn;
      rspHit   <= st.lkHit;
      rspPpn   <= st.lkHit ? wayPpn[st.lkWay] : '0;
      rspAttr  <= st.lkHit ? wayAttr[st.lkWay] : '0;
      missReq  <= st.rspEn && !st.lkHit;
      missVpn  <= lkVpn;
    end
  end
endmodule

// File: rtl/dtlb_cache.sv
module dtlb_cache
  import dtlb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PPN_W    = 20,
  parameter int NUM_SETS = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         lkValid,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] lkVpn,
  input  logic                         instValid,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] instVpn,
  input  logic [PPN_W-1:0]             instPpn,
  input  logic [ATTR_W-1:0]            instAttr,
  input  logic                         invValid,
  input  logic [ADDR_W-1:0]            invOperand,
  output logic                         rspValid,
  output logic                         rspHit,
  output logic [PPN_W-1:0]             rspPpn,
  output logic [ATTR_W-1:0]            rspAttr,
  output logic                         missReq,
  output logic [ADDR_W-PAGE_SHIFT-1:0] missVpn
);
  tlbStrobe_t      st;
  logic [WAYS-1:0] lkMatch, fillValid, fillMatch, dropMatch;
  logic            fillLru;

  dtlb_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .lkValid(lkValid), .instValid(instValid), .invValid(invValid),
    .invOperand(invOperand), .lkMatch(lkMatch), .fillValid(fillValid),
    .fillMatch(fillMatch), .fillLru(fillLru), .dropMatch(dropMatch), .st(st)
  );

  dtlb_store #(.ADDR_W(ADDR_W), .PPN_W(PPN_W), .NUM_SETS(NUM_SETS)) i_store (
    .clk(clk), .rstN(rstN), .st(st), .lkVpn(lkVpn), .instVpn(instVpn),
    .instPpn(instPpn), .instAttr(instAttr),
    .invVpn(invOperand[ADDR_W-1:PAGE_SHIFT]),
    .lkMatch(lkMatch), .fillValid(fillValid), .fillMatch(fillMatch),
    .fillLru(fillLru), .dropMatch(dropMatch), .rspValid(rspValid),
    .rspHit(rspHit), .rspPpn(rspPpn), .rspAttr(rspAttr),
    .missReq(missReq), .missVpn(missVpn)
  );
endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker
  import dtlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PPN_W  = 20
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         lkValid,
  input logic [ADDR_W-PAGE_SHIFT-1:0] lkVpn,
  input logic                         instValid,
  input logic [ADDR_W-PAGE_SHIFT-1:0] instVpn,
  input logic                         invValid,
  input logic [ADDR_W-1:0]            invOperand,
  input logic                         rspValid,
  input logic                         rspHit,
  input logic [PPN_W-1:0]             rspPpn,
  input logic [ATTR_W-1:0]            rspAttr,
  input logic                         missReq,
  input logic [ADDR_W-PAGE_SHIFT-1:0] missVpn
);
  AST_RSP_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid); // R2
  AST_MISS_RAISES_WALK: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> missReq); // R3
  AST_WALK_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> (rspValid && !rspHit)); // R3
  AST_WALK_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> (missVpn == $past(lkVpn))); // R3
  AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspPpn == '0 && rspAttr == '0)); // R3
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(instValid && !invValid) && lkValid && lkVpn == $past(instVpn)) |=> rspHit); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ($past(invValid && invOperand == ADDR_W'(FLUSH_OP)) && lkValid) |=> !rspHit); // R9
endmodule

bind dtlb_cache dtlb_checker #(.ADDR_W(ADDR_W), .PPN_W(PPN_W)) i_checker (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn),
  .instValid(instValid), .instVpn(instVpn), .invValid(invValid),
  .invOperand(invOperand), .rspValid(rspValid), .rspHit(rspHit),
  .rspPpn(rspPpn), .rspAttr(rspAttr), .missReq(missReq), .missVpn(missVpn)
);

// File: tb/test_dtlb_cache.sv
module test_dtlb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int PPN_W  = 20;
  localparam int VPN_W  = ADDR_W - 12;

  logic clk = 1'b0;
  logic rstN;
  logic lkValid, instValid, invValid;
  logic [VPN_W-1:0] lkVpn, instVpn, missVpn;
  logic [PPN_W-1:0] instPpn, rspPpn;
  logic [6:0] instAttr, rspAttr;
  logic [ADDR_W-1:0] invOperand;
  logic rspValid, rspHit, missReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic             hit;
    logic [PPN_W-1:0] ppn;
    logic [6:0]       attr;
    logic [VPN_W-1:0] vpn;
  } expItem_t;

  expItem_t expQ[$];
  string    reqQ[$];
  expItem_t e;
  string    r;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtlb_cache #(.ADDR_W(ADDR_W), .PPN_W(PPN_W), .NUM_SETS(32)) i_dtlb_cache (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn),
    .instValid(instValid), .instVpn(instVpn), .instPpn(instPpn),
    .instAttr(instAttr), .invValid(invValid), .invOperand(invOperand),
    .rspValid(rspValid), .rspHit(rspHit), .rspPpn(rspPpn), .rspAttr(rspAttr),
    .missReq(missReq), .missVpn(missVpn)
  );

  // Monitor: pops one expectation per response, sampled at the falling edge
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected response, actual rspValid=1 expected rspValid=0");
      end else begin
        e = expQ.pop_front();
        r = reqQ.pop_front();
        if (rspHit !== e.hit || rspPpn !== e.ppn || rspAttr !== e.attr ||
            missReq !== !e.hit || (!e.hit && missVpn !== e.vpn)) begin
          errors++;
          $display("FAIL %s: actual hit=%0b ppn=%h attr=%h miss=%0b vpn=%h expected hit=%0b ppn=%h attr=%h miss=%0b vpn=%h",
                   r, rspHit, rspPpn, rspAttr, missReq, missVpn,
                   e.hit, e.ppn, e.attr, !e.hit, e.vpn);
        end
      end
    end
  end

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic hit,
                        input logic [PPN_W-1:0] ppn, input logic [6:0] attr,
                        input string req);
    expItem_t it;
    lkValid = 1'b1;
    lkVpn   = vpn;
    it.hit  = hit;
    it.ppn  = hit ? ppn : '0;
    it.attr = hit ? attr : '0;
    it.vpn  = vpn;
    expQ.push_back(it);
    reqQ.push_back(req);
  endtask

  task automatic install(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input logic [6:0] attr);
    instValid = 1'b1;
    instVpn   = vpn;
    instPpn   = ppn;
    instAttr  = attr;
  endtask

  task automatic inval(input logic [ADDR_W-1:0] op);
    invValid   = 1'b1;
    invOperand = op;
  endtask

  task automatic step();
    @(negedge clk);
    lkValid   = 1'b0;
    instValid = 1'b0;
    invValid  = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2: watchdog expired, actual run incomplete expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; lkValid = 1'b0; instValid = 1'b0; invValid = 1'b0;
    lkVpn = '0; instVpn = '0; instPpn = '0; instAttr = '0; invOperand = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0 || missReq !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual rspValid=%0b missReq=%0b expected 0 0", rspValid, missReq);
    end
    rstN = 1'b1;
    step();

    // R1, R3: empty after reset
    lookup(20'h00123, 0, 0, 0, "R1 R3 first lookup misses"); step();
    // R4: install then hit with data intact
    install(20'h00124, 20'h00004, 7'h66); step();
    lookup(20'h00124, 1, 20'h00004, 7'h66, "R4 installed page hits"); step();
    // R5: same-set partner, both resident
    install(20'h01124, 20'h00007, 7'h7f); step();
    lookup(20'h01124, 1, 20'h00007, 7'h7f, "R5 second way hits");
    step();
    lookup(20'h00124, 1, 20'h00004, 7'h66, "R5 first way still resident"); step();
    // R6: hit on 0x124 makes 0x1124 the victim
    install(20'h02124, 20'h00009, 7'h24); step();
    lookup(20'h00124, 1, 20'h00004, 7'h66, "R6 recently used way kept"); step();
    lookup(20'h02124, 1, 20'h00009, 7'h24, "R6 new page resident"); step();
    lookup(20'h01124, 0, 0, 0, "R6 LRU way evicted"); step();
    // R6: last hit was 0x2124, so 0x124 goes next
    install(20'h03124, 20'h0000a, 7'h01); step();
    lookup(20'h00124, 0, 0, 0, "R6 LRU way evicted again"); step();
    lookup(20'h03124, 1, 20'h0000a, 7'h01, "R6 replacement hits"); step();
    lookup(20'h02124, 1, 20'h00009, 7'h24, "R6 other way kept"); step();
    // R7: reinstall resident page
    install(20'h02124, 20'h00055, 7'h0f); step();
    lookup(20'h02124, 1, 20'h00055, 7'h0f, "R7 overwrite in place"); step();
    lookup(20'h03124, 1, 20'h0000a, 7'h01, "R7 neighbour not evicted"); step();
    // R8: single page invalidate
    inval(32'h02124000); step();
    lookup(20'h02124, 0, 0, 0, "R8 dropped page misses"); step();
    lookup(20'h03124, 1, 20'h0000a, 7'h01, "R8 same-set neighbour kept"); step();
    // R10: unaligned operands ignored
    inval(32'h03124800); step();
    lookup(20'h03124, 1, 20'h0000a, 7'h01, "R10 unaligned operand ignored"); step();
    inval(32'h00000c01); step();
    lookup(20'h03124, 1, 20'h0000a, 7'h01, "R10 near-flush operand ignored"); step();
    // R11: install and invalidate together
    install(20'h07005, 20'h00011, 7'h04); inval(32'h00005000); step();
    lookup(20'h07005, 0, 0, 0, "R11 install discarded"); step();
    // R2: same-edge install not visible, back-to-back lookups
    install(20'h00400, 20'h00022, 7'h06);
    lookup(20'h00400, 0, 0, 0, "R2 pre-edge state used"); step();
    lookup(20'h00400, 1, 20'h00022, 7'h06, "R2 back-to-back first"); step();
    lookup(20'h03124, 1, 20'h0000a, 7'h01, "R2 back-to-back second"); step();
    // R9: flush everything
    install(20'h00200, 20'h00033, 7'h20); step();
    inval(32'h00000c00); step();
    lookup(20'h03124, 0, 0, 0, "R9 flush clears way"); step();
    lookup(20'h00200, 0, 0, 0, "R9 flush clears other set"); step();
    lookup(20'h00400, 0, 0, 0, "R9 flush clears all"); step();

    repeat (3) step();
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2: missing responses actual pending=%0d expected 0", expQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule